// File: doc/BRIEF.md
# Operand Field Decoder with Byte Collector

This block sits after the opcode stage of a variable-length instruction decoder. An instruction's operand bytes arrive one per accepted cycle. They are an addressing-form byte, an optional scaled-index byte, an optional displacement and an optional 8-bit immediate. The block works out the operands these bytes describe and how many of them belong to the instruction.

A `start` pulse opens a new instruction. It latches three register-extension bits and a flag that says whether the opcode carries an 8-bit immediate. From that point the collector takes bytes whenever `byte_valid` is high. It uses each byte it takes to decide which byte comes next.

When the last byte has been taken, `done` pulses for one cycle. The decoded description then stays on the outputs until the next `start`. The description contains:

- the 4-bit register operand;
- either a register-direct index or a memory form (base, index, scale, displacement size and instruction-pointer-relative flag);
- the sign-extended displacement and the immediate byte;
- the byte offset of the immediate and the total operand byte count.

Address arithmetic and opcode meaning are left to the stages downstream.

Top module: `operand_field_decoder`

## Requirements
- R1: The addressing byte splits as mode in bits 7:6, register field in bits 5:3 and rm field in bits 2:0; `reg_idx` is `{ext_r, register field}` for every mode.
- R2: Mode 11 is register-direct: `is_mem`=0, `rm_reg`=`{ext_b, rm}`, no scaled-index byte, `disp_bytes`=0, `has_base`=0, `has_index`=0.
- R3: Mode 01 takes one displacement byte, sign-extended to `ADDR_W` bits. Mode 10 takes four displacement bytes, least significant first, sign-extended from bit 31.
- R4: With mode not 11 and rm low bits 100 (regardless of `ext_b`), a scaled-index byte follows. Its bits 7:6 give `scale` = 1 << code, bits 5:3 give index `{ext_x, field}`, and bits 2:0 give base `{ext_b, field}`. Without this byte, `scale` reads 1.
- R5: A scaled-index byte with index field 100 and `ext_x`=0 means no index (`has_index`=0); with `ext_x`=1 the same field is index register 12.
- R6: A scaled-index byte with base field 101 under mode 00 means no base (`has_base`=0) and a four-byte displacement, whatever `ext_b` is.
- R7: Mode 00 with rm low bits 101 and no scaled-index byte is instruction-pointer relative: `rip_rel`=1, `has_base`=0, four displacement bytes, whatever `ext_b` is. Other memory forms without the scaled-index byte use base `{ext_b, rm}`.
- R8: `imm_offset` = 1 + (scaled-index byte present) + displacement bytes (0, 1 or 4); `op_len` = `imm_offset` + `imm_en` as latched at `start`.
- R9: Bytes are taken in the order addressing byte, scaled-index byte, displacement, immediate. Only cycles with `byte_valid` high are consumed, so idle cycles between bytes change nothing. `imm_value` is the immediate byte.
- R10: `done` is high for exactly the one cycle after the clock edge that takes the last operand byte. After that, `busy` is 0 and every decoded output holds its value until the next `start`.
- R11: While idle, `byte_valid` and `byte_data` are ignored: `done` stays 0 and the decoded outputs do not change.
- R12: After reset, `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Opens a new instruction while idle |
| ext_r | input | 1 | Extension bit for the register field, latched at start |
| ext_x | input | 1 | Extension bit for the index field, latched at start |
| ext_b | input | 1 | Extension bit for the base/rm field, latched at start |
| imm_en | input | 1 | An 8-bit immediate follows, latched at start |
| byte_valid | input | 1 | `byte_data` carries an operand byte this cycle |
| byte_data | input | 8 | Operand byte |
| busy | output | 1 | Collecting bytes |
| done | output | 1 | One-cycle pulse: decode complete |
| reg_idx | output | 4 | Register operand index |
| is_mem | output | 1 | Second operand is in memory |
| rm_reg | output | 4 | Register-direct second operand index |
| has_base | output | 1 | Memory form has a base register |
| base_idx | output | 4 | Base register index |
| has_index | output | 1 | Memory form has an index register |
| index_idx | output | 4 | Index register index |
| scale | output | 4 | Index scale factor 1, 2, 4 or 8 |
| sib_present | output | 1 | A scaled-index byte was part of the instruction |
| rip_rel | output | 1 | Instruction-pointer-relative form |
| disp_bytes | output | 3 | Displacement size in bytes: 0, 1 or 4 |
| disp_value | output | ADDR_W | Sign-extended displacement |
| imm_value | output | 8 | Immediate byte |
| imm_offset | output | 3 | Bytes after the opcode that come before the immediate |
| op_len | output | 3 | Total operand bytes after the opcode |

## Verification
The bench sweeps every addressing byte under every extension-bit and immediate combination. It then sweeps every scaled-index byte under modes 00, 01 and 10, and compares each output field against an arithmetic model.

The sweeps target specific failure modes:

- A design that folded `ext_b` into the checks for rm 100 or 101, or into the check for base 101, would take a scaled-index byte or a displacement it should not. The `done` pulse would then land on the wrong cycle.
- A design that ignored `ext_x` on index field 100 would drop index register 12.
- Displacement bytes carrying both sign values catch a missing or wrong sign extension and swapped byte order.
- Idle gaps between bytes catch a design that consumes bytes when `byte_valid` is low.
- Junk bytes sent while idle catch a decoder whose held results change outside an instruction.

// File: rtl/opdec_pkg.sv
// Package: shared constants, collector state type, decoded operand record
// and the displacement-size rule used by the collector and the field decoder.
package opdec_pkg;
    localparam int BYTE_W   = 8;
    localparam int REG_W    = 4;
    localparam int DLEN_W   = 3;
    localparam int LEN_W    = 3;
    localparam int DISP_MAX = 4;
    localparam int RAW_W    = DISP_MAX * BYTE_W;
    localparam int POS_W    = $clog2(DISP_MAX);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MODRM,
        ST_SIB,
        ST_DISP,
        ST_IMM
    } cst_e;

    typedef struct packed {
        logic [REG_W-1:0]  reg_idx;
        logic              is_mem;
        logic [REG_W-1:0]  rm_reg;
        logic              has_base;
        logic [REG_W-1:0]  base_idx;
        logic              has_index;
        logic [REG_W-1:0]  index_idx;
        logic [REG_W-1:0]  scale;
        logic              sib_present;
        logic              rip_rel;
        logic [DLEN_W-1:0] disp_bytes;
    } opd_t;

    // Displacement bytes for a mode, rm low bits and scaled-index base low bits.
    // base_lo only matters when rm_lo selects the scaled-index byte.
    function automatic logic [DLEN_W-1:0] disp_len(input logic [1:0] md,
                                                   input logic [2:0] rm_lo,
                                                   input logic [2:0] base_lo);
        logic [DLEN_W-1:0] n;
        n = '0;
        case (md)
            2'b01: n = DLEN_W'(1);
            2'b10: n = DLEN_W'(DISP_MAX);
            2'b00: begin
                if (rm_lo == 3'b101)
                    n = DLEN_W'(DISP_MAX);
                else if (rm_lo == 3'b100 && base_lo == 3'b101)
                    n = DLEN_W'(DISP_MAX);
            end
            default: n = '0;
        endcase
        return n;
    endfunction
endpackage

// File: rtl/opdec_fields.sv
// Module: opdec_fields
// Purpose: turns the latched addressing byte, scaled-index byte and the three
// extension bits into the operand record. Purely combinational.
// Assumes: sib is meaningful only when the addressing byte selects it; fields
// with no meaning in the decoded form read as zero (scale reads 1).
module opdec_fields
    import opdec_pkg::*;
(
    input  logic [BYTE_W-1:0] modrm,
    input  logic [BYTE_W-1:0] sib,
    input  logic              ext_r,
    input  logic              ext_x,
    input  logic              ext_b,
    output opd_t              opd
);
    logic [1:0] md;
    logic [2:0] rg;
    logic [2:0] rm;
    logic [1:0] ss;
    logic [2:0] ix;
    logic [2:0] bs;
    logic       mem_form;
    logic       sib_sel;

    assign md       = modrm[7:6];
    assign rg       = modrm[5:3];
    assign rm       = modrm[2:0];
    assign ss       = sib[7:6];
    assign ix       = sib[5:3];
    assign bs       = sib[2:0];
    assign mem_form = (md != 2'b11);
    assign sib_sel  = mem_form && (rm == 3'b100);

    // Build the operand record from the addressing and scaled-index fields.
    always_comb begin
        opd             = '0;
        opd.reg_idx     = {ext_r, rg};
        opd.is_mem      = mem_form;
        opd.scale       = REG_W'(1);
        opd.sib_present = sib_sel;
        opd.disp_bytes  = disp_len(md, rm, bs);
        if (!mem_form) begin
            opd.rm_reg = {ext_b, rm};
        end else if (sib_sel) begin
            opd.scale     = REG_W'(1) << ss;
            opd.has_index = !(ix == 3'b100 && !ext_x);
            opd.index_idx = opd.has_index ? {ext_x, ix} : '0;
            opd.has_base  = !(bs == 3'b101 && md == 2'b00);
            opd.base_idx  = opd.has_base ? {ext_b, bs} : '0;
        end else if (md == 2'b00 && rm == 3'b101) begin
            opd.rip_rel = 1'b1;
        end else begin
            opd.has_base = 1'b1;
            opd.base_idx = {ext_b, rm};
        end
    end
endmodule

// File: rtl/opdec_len.sv
// Module: opdec_len
// Purpose: operand byte counts from the decoded form.
// Assumes: disp_bytes is 0, 1 or 4, so every sum fits in LEN_W bits.
module opdec_len
    import opdec_pkg::*;
(
    input  logic              sib_present,
    input  logic [DLEN_W-1:0] disp_bytes,
    input  logic              imm_flag,
    output logic [LEN_W-1:0]  imm_offset,
    output logic [LEN_W-1:0]  op_len
);
    // Offset of the immediate, then the full length including it.
    always_comb begin
        imm_offset = LEN_W'(1) + LEN_W'(sib_present) + LEN_W'(disp_bytes);
        op_len     = imm_offset + LEN_W'(imm_flag);
    end
endmodule

// File: rtl/opdec_collect.sv
// Module: opdec_collect
// Purpose: byte-stream state machine. It latches the extension bits and the
// immediate flag at start, then takes the addressing byte, the scaled-index
// byte, the displacement (least significant byte first) and the immediate
// in that order, and pulses done after the last one.
// Assumes: start is honoured only while idle; bytes only while busy.
module opdec_collect
    import opdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ext_r,
    input  logic              ext_x,
    input  logic              ext_b,
    input  logic              imm_en,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              busy,
    output logic              done,
    output logic [BYTE_W-1:0] modrm,
    output logic [BYTE_W-1:0] sib,
    output logic [2:0]        ext_rxb,
    output logic              imm_flag,
    output logic [RAW_W-1:0]  disp_raw,
    output logic [BYTE_W-1:0] imm_byte,
    output logic [LEN_W-1:0]  byte_cnt
);
    cst_e              state_q;
    cst_e              after_st;
    logic [BYTE_W-1:0] modrm_q;
    logic [BYTE_W-1:0] sib_q;
    logic [2:0]        ext_q;
    logic              immf_q;
    logic [RAW_W-1:0]  disp_q;
    logic [BYTE_W-1:0] imm_q;
    logic [DLEN_W-1:0] dleft_q;
    logic [POS_W-1:0]  dpos_q;
    logic [LEN_W-1:0]  cnt_q;
    logic              done_q;
    logic [DLEN_W-1:0] dl_now;
    logic              sib_next;

    // Displacement size known at the current byte, and the state after it.
    always_comb begin
        dl_now = '0;
        if (state_q == ST_MODRM)
            dl_now = disp_len(byte_data[7:6], byte_data[2:0], 3'b000);
        else if (state_q == ST_SIB)
            dl_now = disp_len(modrm_q[7:6], 3'b100, byte_data[2:0]);
        if (dl_now != '0)
            after_st = ST_DISP;
        else if (immf_q)
            after_st = ST_IMM;
        else
            after_st = ST_IDLE;
    end

    // An addressing byte with a memory mode and rm low bits 100 calls for a scaled-index byte.
    assign sib_next = (byte_data[7:6] != 2'b11) && (byte_data[2:0] == 3'b100);

    // Sequence through the operand bytes and capture each one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            modrm_q <= '0;
            sib_q   <= '0;
            ext_q   <= '0;
            immf_q  <= 1'b0;
            disp_q  <= '0;
            imm_q   <= '0;
            dleft_q <= '0;
            dpos_q  <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_MODRM;
                        ext_q   <= {ext_r, ext_x, ext_b};
                        immf_q  <= imm_en;
                        modrm_q <= '0;
                        sib_q   <= '0;
                        disp_q  <= '0;
                        imm_q   <= '0;
                        cnt_q   <= '0;
                    end
                end
                ST_MODRM: begin
                    if (byte_valid) begin
                        modrm_q <= byte_data;
                        cnt_q   <= cnt_q + LEN_W'(1);
                        if (sib_next) begin
                            state_q <= ST_SIB;
                        end else begin
                            state_q <= after_st;
                            dleft_q <= dl_now;
                            dpos_q  <= '0;
                            if (after_st == ST_IDLE) done_q <= 1'b1;
                        end
                    end
                end
                ST_SIB: begin
                    if (byte_valid) begin
                        sib_q   <= byte_data;
                        cnt_q   <= cnt_q + LEN_W'(1);
                        state_q <= after_st;
                        dleft_q <= dl_now;
                        dpos_q  <= '0;
                        if (after_st == ST_IDLE) done_q <= 1'b1;
                    end
                end
                ST_DISP: begin
                    if (byte_valid) begin
                        disp_q[{dpos_q, 3'b000} +: BYTE_W] <= byte_data;
                        dpos_q  <= dpos_q + POS_W'(1);
                        dleft_q <= dleft_q - DLEN_W'(1);
                        cnt_q   <= cnt_q + LEN_W'(1);
                        if (dleft_q == DLEN_W'(1)) begin
                            if (immf_q) begin
                                state_q <= ST_IMM;
                            end else begin
                                state_q <= ST_IDLE;
                                done_q  <= 1'b1;
                            end
                        end
                    end
                end
                ST_IMM: begin
                    if (byte_valid) begin
                        imm_q   <= byte_data;
                        cnt_q   <= cnt_q + LEN_W'(1);
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;
    assign modrm    = modrm_q;
    assign sib      = sib_q;
    assign ext_rxb  = ext_q;
    assign imm_flag = immf_q;
    assign disp_raw = disp_q;
    assign imm_byte = imm_q;
    assign byte_cnt = cnt_q;

    // R10: the completion pulse never lasts two cycles
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R10: completion leaves the collector idle
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (state_q == ST_IDLE));

    // R11: captured bytes do not move while idle without a start
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |=>
            ($stable(modrm_q) && $stable(sib_q) && $stable(disp_q) && $stable(imm_q)));

    // R9: the displacement state always has bytes left to take
    a_r9_disp_left: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DISP) |-> (dleft_q != '0));
endmodule

// File: rtl/operand_field_decoder.sv
// Module: operand_field_decoder (top)
// Purpose: collects an instruction's operand bytes and presents the decoded
// operand form, the sign-extended displacement, the immediate and the byte
// counts. Outputs hold from the done pulse until the next start.
// Assumes: ADDR_W is greater than 32.
module operand_field_decoder
    import opdec_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ext_r,
    input  logic              ext_x,
    input  logic              ext_b,
    input  logic              imm_en,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    output logic              busy,
    output logic              done,
    output logic [3:0]        reg_idx,
    output logic              is_mem,
    output logic [3:0]        rm_reg,
    output logic              has_base,
    output logic [3:0]        base_idx,
    output logic              has_index,
    output logic [3:0]        index_idx,
    output logic [3:0]        scale,
    output logic              sib_present,
    output logic              rip_rel,
    output logic [2:0]        disp_bytes,
    output logic [ADDR_W-1:0] disp_value,
    output logic [7:0]        imm_value,
    output logic [2:0]        imm_offset,
    output logic [2:0]        op_len
);
    localparam int SX_SHORT = ADDR_W - BYTE_W;
    localparam int SX_LONG  = ADDR_W - RAW_W;

    logic [BYTE_W-1:0] modrm_w;
    logic [BYTE_W-1:0] sib_w;
    logic [2:0]        ext_w;
    logic              immf_w;
    logic [RAW_W-1:0]  raw_w;
    logic [LEN_W-1:0]  cnt_w;
    opd_t              opd;

    opdec_collect u_collect (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .ext_r      (ext_r),
        .ext_x      (ext_x),
        .ext_b      (ext_b),
        .imm_en     (imm_en),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .busy       (busy),
        .done       (done),
        .modrm      (modrm_w),
        .sib        (sib_w),
        .ext_rxb    (ext_w),
        .imm_flag   (immf_w),
        .disp_raw   (raw_w),
        .imm_byte   (imm_value),
        .byte_cnt   (cnt_w)
    );

    opdec_fields u_fields (
        .modrm (modrm_w),
        .sib   (sib_w),
        .ext_r (ext_w[2]),
        .ext_x (ext_w[1]),
        .ext_b (ext_w[0]),
        .opd   (opd)
    );

    opdec_len u_len (
        .sib_present (opd.sib_present),
        .disp_bytes  (opd.disp_bytes),
        .imm_flag    (immf_w),
        .imm_offset  (imm_offset),
        .op_len      (op_len)
    );

    // Sign-extend the captured displacement to the address width.
    always_comb begin
        case (opd.disp_bytes)
            DLEN_W'(1):        disp_value = {{SX_SHORT{raw_w[BYTE_W-1]}}, raw_w[BYTE_W-1:0]};
            DLEN_W'(DISP_MAX): disp_value = {{SX_LONG{raw_w[RAW_W-1]}}, raw_w};
            default:           disp_value = '0;
        endcase
    end

    assign reg_idx     = opd.reg_idx;
    assign is_mem      = opd.is_mem;
    assign rm_reg      = opd.rm_reg;
    assign has_base    = opd.has_base;
    assign base_idx    = opd.base_idx;
    assign has_index   = opd.has_index;
    assign index_idx   = opd.index_idx;
    assign scale       = opd.scale;
    assign sib_present = opd.sib_present;
    assign rip_rel     = opd.rip_rel;
    assign disp_bytes  = opd.disp_bytes;

    // R8: bytes actually taken agree with the computed operand length
    a_r8_len_count: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cnt_w == op_len));

    // R4: the scale factor is a single power of two
    a_r4_scale_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        opd.sib_present |-> ($countones(opd.scale) == 1));

    // R7: the instruction-pointer-relative form has no base and a long displacement
    a_r7_rip_form: assert property (@(posedge clk) disable iff (!rst_n)
        opd.rip_rel |-> (!opd.has_base && !opd.sib_present && opd.disp_bytes == 3'd4));

    // R2: the register-direct form carries no memory parts
    a_r2_direct_form: assert property (@(posedge clk) disable iff (!rst_n)
        !opd.is_mem |-> (!opd.sib_present && opd.disp_bytes == 3'd0
                         && !opd.has_base && !opd.has_index));
endmodule

// File: tb/sim_operand_field_decoder.sv
module sim_operand_field_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        ext_r = 1'b0, ext_x = 1'b0, ext_b = 1'b0, imm_en = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        busy, done, is_mem, has_base, has_index, sib_present, rip_rel;
    logic [3:0]  reg_idx, rm_reg, base_idx, index_idx, scale;
    logic [2:0]  disp_bytes, imm_offset, op_len;
    logic [63:0] disp_value;
    logic [7:0]  imm_value;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    operand_field_decoder u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .ext_r(ext_r), .ext_x(ext_x), .ext_b(ext_b), .imm_en(imm_en),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .busy(busy), .done(done), .reg_idx(reg_idx), .is_mem(is_mem),
        .rm_reg(rm_reg), .has_base(has_base), .base_idx(base_idx),
        .has_index(has_index), .index_idx(index_idx), .scale(scale),
        .sib_present(sib_present), .rip_rel(rip_rel), .disp_bytes(disp_bytes),
        .disp_value(disp_value), .imm_value(imm_value),
        .imm_offset(imm_offset), .op_len(op_len)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic resync();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Expected values and checks of every decoded field against the model.
    task automatic check_fields(input logic [7:0] m, input logic [7:0] s,
                                input logic r, input logic x, input logic b,
                                input logic f, input logic [7:0] d0, input logic [7:0] d1,
                                input logic [7:0] d2, input logic [7:0] d3,
                                input logic [7:0] iv);
        logic [1:0]  md;
        logic        e_mem, e_sib, e_rip, e_hb, e_hi;
        int          e_dl;
        logic [63:0] e_dv;
        md    = m[7:6];
        e_mem = (md != 2'b11);
        e_sib = e_mem && (m[2:0] == 3'd4);
        e_rip = (md == 2'b00) && !e_sib && (m[2:0] == 3'd5);
        e_dl  = (md == 2'b01) ? 1 : (md == 2'b10) ? 4 :
                ((md == 2'b00) && (e_rip || (e_sib && s[2:0] == 3'd5))) ? 4 : 0;
        e_hb  = e_mem && !e_rip && !(e_sib && md == 2'b00 && s[2:0] == 3'd5);
        e_hi  = e_sib && !(s[5:3] == 3'd4 && !x);
        if (e_dl == 1)      e_dv = {{56{d0[7]}}, d0};
        else if (e_dl == 4) e_dv = {{32{d3[7]}}, d3, d2, d1, d0};
        else                e_dv = '0;
        chk("R1", "reg_idx", 64'(reg_idx), 64'({r, m[5:3]}));
        chk("R2", "is_mem", 64'(is_mem), 64'(e_mem));
        if (!e_mem) chk("R2", "rm_reg", 64'(rm_reg), 64'({b, m[2:0]}));
        chk("R4", "sib_present", 64'(sib_present), 64'(e_sib));
        chk("R4", "scale", 64'(scale), e_sib ? (64'd1 << s[7:6]) : 64'd1);
        chk("R5", "has_index", 64'(has_index), 64'(e_hi));
        if (e_hi) chk("R5", "index_idx", 64'(index_idx), 64'({x, s[5:3]}));
        chk("R6", "has_base", 64'(has_base), 64'(e_hb));
        if (e_hb) chk("R7", "base_idx", 64'(base_idx),
                      e_sib ? 64'({b, s[2:0]}) : 64'({b, m[2:0]}));
        chk("R7", "rip_rel", 64'(rip_rel), 64'(e_rip));
        chk("R3", "disp_bytes", 64'(disp_bytes), 64'(e_dl));
        chk("R3", "disp_value", disp_value, e_dv);
        chk("R8", "imm_offset", 64'(imm_offset), 64'(1 + int'(e_sib) + e_dl));
        chk("R8", "op_len", 64'(op_len), 64'(1 + int'(e_sib) + e_dl + int'(f)));
        if (f) chk("R9", "imm_value", 64'(imm_value), 64'(iv));
    endtask

    // Feed one instruction's operand bytes and check the result.
    task automatic run_one(input logic [7:0] m, input logic [7:0] s,
                           input logic r, input logic x, input logic b, input logic f,
                           input logic [7:0] d0, input logic [7:0] d1,
                           input logic [7:0] d2, input logic [7:0] d3,
                           input logic [7:0] iv, input bit gap);
        logic [7:0] seq [8];
        int         n;
        logic       e_sib;
        int         e_dl;
        logic [3:0] held;
        e_sib = (m[7:6] != 2'b11) && (m[2:0] == 3'd4);
        e_dl  = (m[7:6] == 2'b01) ? 1 : (m[7:6] == 2'b10) ? 4 :
                ((m[7:6] == 2'b00) && ((!e_sib && m[2:0] == 3'd5) ||
                                       (e_sib && s[2:0] == 3'd5))) ? 4 : 0;
        n = 0;
        seq[n] = m; n++;
        if (e_sib) begin seq[n] = s; n++; end
        if (e_dl >= 1) begin seq[n] = d0; n++; end
        if (e_dl == 4) begin seq[n] = d1; n++; seq[n] = d2; n++; seq[n] = d3; n++; end
        if (f) begin seq[n] = iv; n++; end
        start = 1'b1; ext_r = r; ext_x = x; ext_b = b; imm_en = f;
        @(negedge clk);
        start = 1'b0; ext_r = 1'b0; ext_x = 1'b0; ext_b = 1'b0; imm_en = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (gap) begin
                byte_valid = 1'b0;
                byte_data  = 8'hEE;
                @(negedge clk);
            end
            byte_valid = 1'b1;
            byte_data  = seq[i];
            @(negedge clk);
        end
        byte_valid = 1'b0;
        byte_data  = 8'h00;
        chk("R10", "done after last byte", 64'(done), 64'd1);
        if (done !== 1'b1) begin
            resync();
        end else begin
            chk("R10", "busy at done", 64'(busy), 64'd0);
            check_fields(m, s, r, x, b, f, d0, d1, d2, d3, iv);
            held = reg_idx;
            @(negedge clk);
            chk("R10", "done single cycle", 64'(done), 64'd0);
            chk("R10", "reg_idx held", 64'(reg_idx), 64'(held));
        end
    endtask

    initial begin
        int c;
        c = 0;
        while (!finished && c < 190000) begin
            @(posedge clk);
            c++;
        end
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<190000 cycles", c);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R12", "busy after reset", 64'(busy), 64'd0);
        chk("R12", "done after reset", 64'(done), 64'd0);

        // Worked example: reg 8, base 2, index 9, scale 8, short displacement 64, immediate 0C.
        run_one(8'h44, 8'hCA, 1'b1, 1'b1, 1'b0, 1'b1, 8'h40, 8'h00, 8'h00, 8'h00, 8'h0C, 1'b0);
        chk("R4", "example index", 64'(index_idx), 64'd9);
        chk("R4", "example scale", 64'(scale), 64'd8);
        chk("R3", "example disp", disp_value, 64'd64);

        // R11: junk bytes while idle change nothing.
        for (int k = 0; k < 4; k++) begin
            byte_valid = 1'b1;
            byte_data  = 8'(8'hC0 + k);
            @(negedge clk);
            chk("R11", "done while idle", 64'(done), 64'd0);
        end
        byte_valid = 1'b0;
        check_fields(8'h44, 8'hCA, 1'b1, 1'b1, 1'b0, 1'b1, 8'h40, 8'h00, 8'h00, 8'h00, 8'h0C);

        // Every addressing byte under every extension and immediate setting.
        for (int m = 0; m < 256; m++) begin
            for (int e = 0; e < 8; e++) begin
                for (int f = 0; f < 2; f++) begin
                    run_one(8'(m), 8'(m * 29 + e * 71 + f * 13),
                            e[2], e[1], e[0], f[0],
                            8'(m ^ (e * 32 + f * 16 + 3)), 8'(e * 33), 8'(m + 7),
                            8'(8'h80 ^ m[7:0]), 8'(m ^ 8'hC3), (m % 5) == 0);
                end
            end
        end

        // Every scaled-index byte under modes 00, 01, 10 and both index extensions.
        for (int s = 0; s < 256; s++) begin
            for (int md = 0; md < 3; md++) begin
                for (int x = 0; x < 2; x++) begin
                    run_one(8'({md[1:0], 3'b101, 3'b100}), 8'(s), 1'b1, x[0], s[0],
                            s[1], 8'(s), 8'(~s), 8'(s + 1), 8'(s * 3), 8'(s ^ 8'h5A),
                            (s % 7) == 0);
                end
            end
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule